// File: doc/BRIEF.md
# Switchable Clock-Rate Prescaler

This block derives the core timing and the peripheral timing of a small processor from a single crystal-rate clock. In standard mode the core advances one phase on every second input clock, so a machine cycle of six phases spans twelve input periods. In fast mode the halving stage is bypassed: the core advances every input clock and a machine cycle spans six input periods. The core phase clock is delivered as a single-cycle `core_tick_o` enable, with the current phase index and a machine-cycle strobe beside it.

A global fast request chooses the mode. The request is taken over only on the input edge where the internal divide-by-two clock rises, so the phase enable never loses its alignment when the mode changes in either direction. Seven peripherals each have a fast bit that picks a strobe period of six or twelve input periods. These bits have an effect only while fast mode is in force. All strobes come from one free-running twelve-count base, so a strobe period is always a whole multiple of six.

Top module: `clkrate_prescaler`

## Requirements
- R1: While reset is held and on release, `core_tick_o`, `mcycle_o` and every `ptick_o` bit are 0 and `phase_o` is 0, whatever the control inputs are.
- R2: In standard mode `core_tick_o` is high on every second input cycle and never on two cycles in a row, giving 12 input periods per machine cycle.
- R3: In fast mode `core_tick_o` is high on every input cycle, giving 6 input periods per machine cycle.
- R4: Counting input edges from reset release as 1, 2, 3 and so on, the mode in force changes only at an odd edge, where it takes the value `fast_req_i` held before that edge. After edge n, `core_tick_o` is high when n is odd or fast mode is in force.
- R5: `phase_o` steps 0,1,...,5,0 by one on each cycle where `core_tick_o` is high. `mcycle_o` is high exactly on the tick cycle where `phase_o` is 5.
- R6: A peripheral whose fast bit is 1 while fast mode is in force strobes once every 6 input periods (4 strobes in any 24 consecutive cycles). Otherwise it strobes once every 12 periods (2 strobes in 24 cycles).
- R7: While standard mode is in force, the peripheral fast bits have no effect: every peripheral strobes once every 12 input periods.
- R8: Two strobes of the same peripheral are never fewer than 6 input periods apart, including when its fast bit or the mode changes.
- R9: Bit i of `pfast_i` controls bit i of `ptick_o`. The order is 0 timer 0, 1 timer 1, 2 timer 2, 3 serial port, 4 counter array, 5 watchdog, 6 SPI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_req_i | input | 1 | Global fast-mode request |
| pfast_i | input | 7 | Per-peripheral fast bits (see R9) |
| core_tick_o | output | 1 | Core phase enable, one input cycle wide |
| phase_o | output | 3 | Current core phase, 0 to 5 |
| mcycle_o | output | 1 | Machine-cycle strobe on the last phase tick |
| ptick_o | output | 7 | Per-peripheral strobes (see R9) |

## Verification
The mode changeover can fall in the same cycle as a core tick, a machine-cycle strobe or a fast peripheral slot. The bench toggles `fast_req_i` every seven cycles, which places each request on both even and odd edges, and walks the phase counter through every value. On each cycle it compares the tick, phase and strobe against an edge-parity model of R4 and R5. Peripheral strobes that fall close to a changeover are judged by the minimum-spacing property, and the steady-state strobe counts are judged in 24-cycle windows for all 256 settings of the mode and peripheral bits.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;

  localparam int unsigned DEF_PHASES = 6;
  localparam int unsigned DEF_NPERIPH = 7;

  typedef enum logic [2:0] {
    PER_TMR0   = 3'd0,
    PER_TMR1   = 3'd1,
    PER_TMR2   = 3'd2,
    PER_SERIAL = 3'd3,
    PER_CNTARR = 3'd4,
    PER_WDOG   = 3'd5,
    PER_SPI    = 3'd6
  } periph_e;

  // Input periods between strobes for a peripheral
  function automatic int unsigned periph_period(input logic gfast, input logic pfast,
                                                input int unsigned phases);
    return (gfast && pfast) ? phases : 2 * phases;
  endfunction

  // Input periods per machine cycle for the core
  function automatic int unsigned core_period(input logic gfast, input int unsigned phases);
    return gfast ? phases : 2 * phases;
  endfunction

  // Whether a base count value is a strobe slot for the chosen rate
  function automatic logic slot_hit(input int unsigned cnt, input logic fast,
                                    input int unsigned phases);
    if (fast) return (cnt == phases - 1) || (cnt == 2 * phases - 1);
    return cnt == 2 * phases - 1;
  endfunction

endpackage

// File: rtl/clkrate_mode_sync.sv
module clkrate_mode_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_req_i,
  output logic half_q_o,
  output logic fast_act_o
);
  logic half_q;
  logic fast_act;
  logic half_rise;

  // half_q becomes 1 at this edge: the divided clock's rising edge
  assign half_rise = ~half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q   <= 1'b0;
      fast_act <= 1'b0;
    end else begin
      half_q <= ~half_q;
      if (half_rise) fast_act <= fast_req_i;
    end
  end

  assign half_q_o   = half_q;
  assign fast_act_o = fast_act;
endmodule

// File: rtl/clkrate_phase_gen.sv
module clkrate_phase_gen #(
  parameter int unsigned PHASES = 6,
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [PW-1:0] phase_o,
  output logic          mcycle_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] phase;
  logic          at_last;

  assign at_last = (phase == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= '0;
    end else if (tick_i) begin
      phase <= at_last ? '0 : phase + 1'b1;
    end
  end

  assign phase_o  = phase;
  assign mcycle_o = tick_i & at_last;
endmodule

// File: rtl/clkrate_periph_tick.sv
module clkrate_periph_tick
  import clkrate_pkg::*;
#(
  parameter int unsigned PHASES     = 6,
  parameter int unsigned NUM_PERIPH = 7,
  localparam int unsigned BASE = 2 * PHASES,
  localparam int unsigned CW   = $clog2(BASE)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fast_act_i,
  input  logic [NUM_PERIPH-1:0] pfast_i,
  output logic [NUM_PERIPH-1:0] ptick_o
);
  localparam logic [CW-1:0] CLAST = CW'(BASE - 1);

  logic [CW-1:0] base_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_cnt <= '0;
    else         base_cnt <= (base_cnt == CLAST) ? '0 : base_cnt + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_per
    logic eff_fast;
    assign eff_fast    = fast_act_i & pfast_i[gi];
    assign ptick_o[gi] = rst_ni & slot_hit(int'(base_cnt), eff_fast, PHASES);
  end
endmodule

// File: rtl/clkrate_prescaler.sv
module clkrate_prescaler
  import clkrate_pkg::*;
#(
  parameter int unsigned PHASES     = DEF_PHASES,
  parameter int unsigned NUM_PERIPH = DEF_NPERIPH,
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fast_req_i,
  input  logic [NUM_PERIPH-1:0] pfast_i,
  output logic                  core_tick_o,
  output logic [PW-1:0]         phase_o,
  output logic                  mcycle_o,
  output logic [NUM_PERIPH-1:0] ptick_o
);
  logic half_q;
  logic fast_act;

  clkrate_mode_sync u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_req_i (fast_req_i),
    .half_q_o   (half_q),
    .fast_act_o (fast_act)
  );

  // Divided clock high, or divider bypassed
  assign core_tick_o = half_q | fast_act;

  clkrate_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (core_tick_o),
    .phase_o  (phase_o),
    .mcycle_o (mcycle_o)
  );

  clkrate_periph_tick #(.PHASES(PHASES), .NUM_PERIPH(NUM_PERIPH)) u_per (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_act_i (fast_act),
    .pfast_i    (pfast_i),
    .ptick_o    (ptick_o)
  );
endmodule

// File: rtl/clkrate_prescaler_chk.sv
module clkrate_prescaler_chk #(
  parameter int unsigned PHASES     = 6,
  parameter int unsigned NUM_PERIPH = 7,
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int unsigned GW = $clog2(2 * PHASES) + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  half_q,
  input logic                  fast_act,
  input logic                  core_tick,
  input logic [PW-1:0]         phase,
  input logic                  mcycle,
  input logic [NUM_PERIPH-1:0] ptick
);
  localparam logic [GW-1:0] GSAT = GW'(2 * PHASES);
  localparam logic [GW-1:0] GMIN = GW'(PHASES - 1);

  AST_STD_NO_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_act && core_tick) |=> !core_tick); // R2

  AST_FAST_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_act && $past(fast_act)) |-> (phase != $past(phase))); // R3

  AST_MODE_SAFE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_act != $past(fast_act)) |-> half_q); // R4

  AST_MCYCLE_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcycle |=> (phase == '0)); // R5

  for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_gap
    logic [GW-1:0] gap;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         gap <= GSAT;
      else if (ptick[gi])  gap <= '0;
      else if (gap != GSAT) gap <= gap + 1'b1;
    end
    AST_PERIPH_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptick[gi] |-> (gap >= GMIN)); // R8
  end
endmodule

bind clkrate_prescaler clkrate_prescaler_chk #(.PHASES(PHASES), .NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .half_q    (half_q),
  .fast_act  (fast_act),
  .core_tick (core_tick_o),
  .phase     (phase_o),
  .mcycle    (mcycle_o),
  .ptick     (ptick_o)
);

// File: tb/tb_clkrate_prescaler.sv
`timescale 1ns/1ps
module tb_clkrate_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_req = 1'b0;
  logic [6:0] pfast = '0;
  logic       core_tick;
  logic [2:0] phase;
  logic       mcycle;
  logic [6:0] ptick;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  clkrate_prescaler dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fast_req_i  (fast_req),
    .pfast_i     (pfast),
    .core_tick_o (core_tick),
    .phase_o     (phase),
    .mcycle_o    (mcycle),
    .ptick_o     (ptick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edge-parity model of R4 and phase stepping of R5
  int n;
  bit fa_m;
  int ph_m;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0; fa_m = 1'b0; ph_m = 0;
    end else begin
      if (fa_m || (n % 2 == 1)) ph_m = (ph_m + 1) % 6;
      if (n % 2 == 0) fa_m = fast_req;
      n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit exp_tick;
    int ct, mc;
    int pc[7];
    // R1: reset with every control asserted
    fast_req = 1'b1; pfast = '1;
    repeat (3) @(negedge clk);
    chk(core_tick == 0, "R1 core_tick", core_tick, 0);
    chk(mcycle == 0, "R1 mcycle", mcycle, 0);
    chk(ptick == 0, "R1 ptick", ptick, 0);
    chk(phase == 0, "R1 phase", phase, 0);
    fast_req = 1'b0; pfast = '0;
    rst_n = 1'b1;

    // R2/R3/R6/R7/R9: exhaustive sweep, steady-state windows
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 128; p++) begin
        fast_req = g[0]; pfast = p[6:0];
        repeat (4) @(negedge clk);
        ct = 0; mc = 0;
        for (int i = 0; i < 7; i++) pc[i] = 0;
        for (int k = 0; k < 24; k++) begin
          @(negedge clk);
          ct += int'(core_tick);
          mc += int'(mcycle);
          for (int i = 0; i < 7; i++) pc[i] += int'(ptick[i]);
        end
        chk(ct == (g ? 24 : 12), g ? "R3 core ticks" : "R2 core ticks", ct, g ? 24 : 12);
        chk(mc == (g ? 4 : 2), g ? "R3 machine cycles" : "R2 machine cycles", mc, g ? 4 : 2);
        for (int i = 0; i < 7; i++) begin
          int e;
          e = (g == 1 && p[i]) ? 4 : 2;
          if (g == 0 && p[i]) chk(pc[i] == e, "R7 masked peripheral bit", pc[i], e);
          else                chk(pc[i] == e, "R6 R9 peripheral strobes", pc[i], e);
        end
      end
    end

    // R4/R5: changeover trace, requests on both edge parities
    pfast = 7'h55;
    for (int i = 0; i < 112; i++) begin
      @(negedge clk);
      exp_tick = fa_m || (n % 2 == 1);
      chk(core_tick == exp_tick, "R4 tick at changeover", core_tick, exp_tick);
      chk(int'(phase) == ph_m, "R5 phase", phase, ph_m);
      chk(mcycle == (exp_tick && ph_m == 5), "R5 mcycle", mcycle, exp_tick && ph_m == 5);
      if (i % 7 == 3) fast_req = ~fast_req;
      if (i % 16 == 9) pfast = ~pfast;  // R8 spacing judged by the checker
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule